// File: doc/BRIEF.md
# Two-Way Set-Associative Cache

This block sits between a word-addressed processor port and a slower backing memory. Each request address is cut into a tag and a set index. The offset field is empty because a block holds one word. Both ways of the indexed set are compared in the same cycle. On a hit, the read data comes back combinationally and the access completes in that cycle. On a miss, the processor is stalled while the block is fetched. An empty way is used first. When both ways hold data, a single least-recently-used bit per set picks the victim.

A parameter selects the write policy. In write-through mode, every processor write also goes to backing memory before the access completes. In write-back mode, writes stay in the cache and mark the block dirty. A dirty block is written to memory only when it is evicted or flushed. Write misses allocate the block first and then perform the write as a hit.

A flush request writes out every dirty block and then empties the cache. Two saturating counters record the outcome of each new lookup.

Top module: `twoway_cache`

## Requirements
- R1: The word address splits into a set index (its low LOG_SETS bits) and a tag (the remaining high bits). A lookup hits only when a way of the indexed set is valid and its stored tag equals the request tag.
- R2: On a miss, an invalid way is filled before any valid block is displaced. Way 0 is chosen before way 1.
- R3: Each set keeps one LRU bit. Every completed read or write hit points it at the other way. A miss with both ways valid evicts the way the bit names.
- R4: With 2 sets, reading words 0, 2, 0, 1, 4, 0 from reset gives miss, miss, hit, miss, miss, hit. A later read of word 2 misses because that word was displaced.
- R5: A read returns the most recent value written to that word through the processor port, or the backing-memory value if the word was never written.
- R6: When WRITE_BACK is 0, a write hit updates the cached word. It then issues the same address and data to backing memory, and the processor stays stalled until memory accepts the write.
- R7: When WRITE_BACK is 1, a write hit leaves backing memory unchanged and marks the block dirty. A dirty victim is written to its own address before the replacement block is read.
- R8: A write miss fetches the block (after any dirty write-out) and then completes as a write hit. A following read of that word hits and returns the written data.
- R9: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata steady until a cycle with mem_ready high. cpu_stall is high from a miss until the access completes, and is low whenever cpu_req is low.
- R10: A flush_req taken while idle writes out each valid dirty block. The order is set 0 way 0, set 0 way 1, set 1 way 0, and so on. All blocks are then made invalid, and flush_done is high for exactly one cycle.
- R11: hit_count and miss_count reset to 0. Exactly one of them increments on the first lookup of each processor request, and neither counts the retry after a fill. Each counter holds at 2^32-1.
- R12: After reset, every block is invalid, and cpu_stall, mem_req and flush_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid in the completing cycle |
| cpu_stall | output | 1 | Access not yet complete |
| flush_req | input | 1 | Start a flush (sampled when idle) |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| mem_req | output | 1 | Backing-memory request valid |
| mem_we | output | 1 | Backing-memory write |
| mem_addr | output | ADDR_W | Backing-memory word address |
| mem_wdata | output | DATA_W | Backing-memory write data |
| mem_ready | input | 1 | Backing memory accepts or answers the request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| hit_count | output | 32 | Saturating hit counter |
| miss_count | output | 32 | Saturating miss counter |

## Verification
The checks on request stability and on the write-through write source assume the following about the processor. It holds cpu_addr, cpu_we and cpu_wdata steady for as long as cpu_stall is high. It does not raise flush_req in the middle of an access. They also assume the memory raises mem_ready only while mem_req is high, and presents mem_rdata together with mem_ready.

The bench respects both sides. Its access task drives a request at a falling edge and leaves it untouched until the stall drops. It pulses flush_req only between accesses. Its memory model answers after a random delay of zero to three cycles and lowers mem_ready after every transfer.

// File: rtl/twoway_cache.sv
`timescale 1ns/1ps
module twoway_cache #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LOG_SETS   = 1,
  parameter bit WRITE_BACK = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [31:0]       hit_count,
  output logic [31:0]       miss_count
);
  localparam int SETS  = 1 << LOG_SETS;
  localparam int TAG_W = ADDR_W - LOG_SETS;
  localparam int PTR_W = LOG_SETS + 1;

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_THRU, S_FLUSH, S_FDONE} state_t;

  state_t            state_q;
  logic [TAG_W-1:0]  tag_q   [SETS][2];
  logic [DATA_W-1:0] data_q  [SETS][2];
  logic [1:0]        valid_q [SETS];
  logic [1:0]        dirty_q [SETS];
  logic [SETS-1:0]   lru_q;
  logic              vic_q;
  logic              replay_q;
  logic [PTR_W-1:0]  fptr_q;

  // R1: index from the low bits, tag from the rest
  wire [LOG_SETS-1:0] idx = cpu_addr[LOG_SETS-1:0];
  wire [TAG_W-1:0]    tag = cpu_addr[ADDR_W-1:LOG_SETS];
  wire [1:0] match = {valid_q[idx][1] && (tag_q[idx][1] == tag),
                      valid_q[idx][0] && (tag_q[idx][0] == tag)};
  wire hit  = |match;
  wire hway = match[1];

  // R2/R3: empty way first, else the LRU way
  wire victim = !valid_q[idx][0] ? 1'b0 :
                !valid_q[idx][1] ? 1'b1 : lru_q[idx];

  wire [LOG_SETS-1:0] fset = fptr_q[PTR_W-1:1];
  wire                fway = fptr_q[0];
  wire fdirty    = valid_q[fset][fway] && dirty_q[fset][fway];
  wire fptr_last = &fptr_q;

  wire lookup     = (state_q == S_IDLE) && cpu_req && !flush_req;
  wire thru_write = !WRITE_BACK && cpu_we;
  wire done_hit   = lookup && hit && !thru_write;

  assign cpu_stall  = cpu_req && !(done_hit || ((state_q == S_THRU) && mem_ready));
  assign cpu_rdata  = data_q[idx][hway];
  assign flush_done = (state_q == S_FDONE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cpu_addr;
    mem_wdata = cpu_wdata;
    case (state_q)
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[idx][vic_q], idx};
        mem_wdata = data_q[idx][vic_q];
      end
      S_FILL: mem_req = 1'b1;
      S_THRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      S_FLUSH: begin
        mem_req   = fdirty;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[fset][fway], fset};
        mem_wdata = data_q[fset][fway];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      vic_q      <= 1'b0;
      replay_q   <= 1'b0;
      fptr_q     <= '0;
      lru_q      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      case (state_q)
        S_IDLE: begin
          if (flush_req) begin
            state_q  <= S_FLUSH;
            fptr_q   <= '0;
            replay_q <= 1'b0;
          end else if (cpu_req) begin
            // R11: count only the first lookup of a request
            if (!replay_q) begin
              if (hit && hit_count != '1)        hit_count  <= hit_count + 32'd1;
              else if (!hit && miss_count != '1) miss_count <= miss_count + 32'd1;
            end
            if (hit) begin
              lru_q[idx] <= !hway;
              replay_q   <= 1'b0;
              if (cpu_we) begin
                data_q[idx][hway] <= cpu_wdata;
                if (WRITE_BACK) dirty_q[idx][hway] <= 1'b1;
                else            state_q <= S_THRU;
              end
            end else begin
              vic_q   <= victim;
              state_q <= (WRITE_BACK && valid_q[idx][victim] && dirty_q[idx][victim])
                         ? S_EVICT : S_FILL;
            end
          end
        end
        S_EVICT: if (mem_ready) state_q <= S_FILL;
        S_FILL: if (mem_ready) begin
          tag_q[idx][vic_q]   <= tag;
          data_q[idx][vic_q]  <= mem_rdata;
          valid_q[idx][vic_q] <= 1'b1;
          dirty_q[idx][vic_q] <= 1'b0;
          replay_q            <= 1'b1;
          state_q             <= S_IDLE;
        end
        S_THRU: if (mem_ready) state_q <= S_IDLE;
        S_FLUSH: if (!fdirty || mem_ready) begin
          if (fdirty) dirty_q[fset][fway] <= 1'b0;
          if (fptr_last) state_q <= S_FDONE;
          else           fptr_q  <= fptr_q + PTR_W'(1);
        end
        S_FDONE: begin
          for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
          end
          lru_q   <= '0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twoway_cache_chk.sv
`timescale 1ns/1ps
module twoway_cache_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_stall,
  input logic              flush_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [31:0]       hit_count,
  input logic [31:0]       miss_count
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R9
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall);

  // R10
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !mem_req && !cpu_stall);

  // R11
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hit_count >= $past(hit_count) && miss_count >= $past(miss_count));

  // R11
  one_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

  // R6
  thru_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK && mem_req && mem_we |-> cpu_req && cpu_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata);
endmodule

bind twoway_cache twoway_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .flush_done(flush_done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .hit_count(hit_count), .miss_count(miss_count));

// File: tb/twoway_cache_bench.sv
`timescale 1ns/1ps
module cache_backing_mem #(parameter int AW = 8, parameter int DW = 32)(
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem  [1<<AW];
  logic [AW-1:0] wlog [16];
  int wlog_n;
  int wait_n;
  initial begin
    ready = 1'b0; rdata = '0; wlog_n = 0; wait_n = 0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = i * 32'h9E3779B1;
  end
  always @(negedge clk) begin
    if (ready) begin
      ready  <= 1'b0;
      wait_n <= $urandom_range(0, 3);
    end else if (req) begin
      if (wait_n == 0) begin
        ready <= 1'b1;
        rdata <= mem[addr];
      end else wait_n <= wait_n - 1;
    end
  end
  always @(posedge clk) if (req && ready && we) begin
    mem[addr] <= wdata;
    if (wlog_n < 16) wlog[wlog_n] <= addr;
    wlog_n <= wlog_n + 1;
  end
endmodule

module twoway_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req[2], cpu_we[2], cpu_stall[2], flush_req[2], flush_done[2];
  logic [7:0]  cpu_addr[2], mem_addr[2];
  logic [31:0] cpu_wdata[2], cpu_rdata[2], mem_wdata[2], mem_rdata[2], hits[2], misses[2];
  logic        mem_req[2], mem_we[2], mem_ready[2];

  twoway_cache #(.WRITE_BACK(1'b1)) u_twoway_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]),
    .cpu_wdata(cpu_wdata[0]), .cpu_rdata(cpu_rdata[0]), .cpu_stall(cpu_stall[0]),
    .flush_req(flush_req[0]), .flush_done(flush_done[0]), .mem_req(mem_req[0]), .mem_we(mem_we[0]),
    .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_ready(mem_ready[0]),
    .mem_rdata(mem_rdata[0]), .hit_count(hits[0]), .miss_count(misses[0]));
  twoway_cache #(.WRITE_BACK(1'b0)) u_twoway_cache_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]),
    .cpu_wdata(cpu_wdata[1]), .cpu_rdata(cpu_rdata[1]), .cpu_stall(cpu_stall[1]),
    .flush_req(flush_req[1]), .flush_done(flush_done[1]), .mem_req(mem_req[1]), .mem_we(mem_we[1]),
    .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_ready(mem_ready[1]),
    .mem_rdata(mem_rdata[1]), .hit_count(hits[1]), .miss_count(misses[1]));
  cache_backing_mem u_mem0 (.clk(clk), .req(mem_req[0]), .we(mem_we[0]), .addr(mem_addr[0]),
    .wdata(mem_wdata[0]), .ready(mem_ready[0]), .rdata(mem_rdata[0]));
  cache_backing_mem u_mem1 (.clk(clk), .req(mem_req[1]), .we(mem_we[1]), .addr(mem_addr[1]),
    .wdata(mem_wdata[1]), .ready(mem_ready[1]), .rdata(mem_rdata[1]));

  int n_chk = 0, n_err = 0;
  logic [31:0] shadow [2][256];
  bit          mval [2][2][2];
  logic [6:0]  mtag [2][2][2];
  bit          mlru [2][2];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // expected hit per R1-style tag match, R2 fill order and R3 LRU
  function automatic bit predict(int i, logic [7:0] a);
    int  s = int'(a[0]);
    bit  w;
    for (int k = 0; k < 2; k++)
      if (mval[i][s][k] && mtag[i][s][k] == a[7:1]) begin
        mlru[i][s] = (k == 0);
        return 1'b1;
      end
    w = !mval[i][s][0] ? 1'b0 : !mval[i][s][1] ? 1'b1 : mlru[i][s];
    mval[i][s][w] = 1'b1;
    mtag[i][s][w] = a[7:1];
    mlru[i][s]    = !w;
    return 1'b0;
  endfunction

  task automatic op(int i, bit we, logic [7:0] a, logic [31:0] wd, string tg,
                    output bit h, output bit st);
    logic [31:0] h0, rd;
    bit ph;
    ph = predict(i, a);
    @(negedge clk);
    h0 = hits[i];
    cpu_req[i] = 1'b1; cpu_we[i] = we; cpu_addr[i] = a; cpu_wdata[i] = wd;
    st = 1'b0;
    #1;
    while (cpu_stall[i]) begin st = 1'b1; @(negedge clk); #1; end
    rd = cpu_rdata[i];
    @(negedge clk);
    cpu_req[i] = 1'b0; cpu_we[i] = 1'b0;
    h = (hits[i] != h0);
    check({tg, " R1 hit"}, 32'(h), 32'(ph));
    if (!we) check({tg, " R5 data"}, rd, shadow[i][a]);
    else shadow[i][a] = wd;
  endtask

  task automatic do_flush(int i);
    @(negedge clk); flush_req[i] = 1'b1;
    @(negedge clk); flush_req[i] = 1'b0;
    while (!flush_done[i]) @(negedge clk);
    @(negedge clk);
    check("R10 done pulse one cycle", 32'(flush_done[i]), 32'd0);
    for (int s = 0; s < 2; s++) begin mval[i][s][0] = 0; mval[i][s][1] = 0; mlru[i][s] = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit h, st;
    logic [31:0] v;
    bit trace_hit [6] = '{0, 0, 1, 0, 0, 1};
    logic [7:0] trace_adr [6] = '{8'd0, 8'd2, 8'd0, 8'd1, 8'd4, 8'd0};
    void'($urandom(32'd61));
    for (int i = 0; i < 2; i++) begin
      cpu_req[i] = 0; cpu_we[i] = 0; cpu_addr[i] = 0; cpu_wdata[i] = 0; flush_req[i] = 0;
      for (int a = 0; a < 256; a++) shadow[i][a] = a * 32'h9E3779B1;
      for (int s = 0; s < 2; s++) begin mval[i][s][0] = 0; mval[i][s][1] = 0; mlru[i][s] = 0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 2; i++) begin  // R12, R11
      check("R12 stall after reset", 32'(cpu_stall[i]), 0);
      check("R12 mem_req after reset", 32'(mem_req[i]), 0);
      check("R12 flush_done after reset", 32'(flush_done[i]), 0);
      check("R11 counters after reset", hits[i] | misses[i], 0);
    end

    // R4 trace
    for (int k = 0; k < 6; k++) begin
      op(0, 0, trace_adr[k], 0, "R4 trace", h, st);
      check("R4 trace outcome", 32'(h), 32'(trace_hit[k]));
      if (k == 0) check("R9 stall on miss", 32'(st), 1);
      if (k == 2) check("R9 no stall on hit", 32'(st), 0);
    end
    op(0, 0, 8'd2, 0, "R3 evicted", h, st);
    check("R3 word 2 displaced", 32'(h), 0);
    check("R11 hit total", hits[0], 2);
    check("R11 miss total", misses[0], 5);

    // R7 write-back: stale until eviction
    op(0, 1, 8'd0, 32'hDEAD0000, "R7 write hit", h, st);
    check("R7 write hit", 32'(h), 1);
    check("R7 memory stale", u_mem0.mem[0], 8'd0 * 32'h9E3779B1);
    op(0, 0, 8'd8, 0, "R7 evict a", h, st);
    op(0, 0, 8'd10, 0, "R7 evict b", h, st);
    check("R7 dirty written back", u_mem0.mem[0], 32'hDEAD0000);

    // R8 write allocate
    op(0, 1, 8'h31, 32'h0000BEEF, "R8 write miss", h, st);
    check("R8 write miss counted", 32'(h), 0);
    op(0, 0, 8'h31, 0, "R8 readback", h, st);
    check("R8 readback hits", 32'(h), 1);

    // R6 write-through
    op(1, 0, 8'd5, 0, "R6 fill", h, st);
    op(1, 1, 8'd5, 32'h12345678, "R6 write hit", h, st);
    check("R6 memory updated", u_mem1.mem[5], 32'h12345678);
    op(1, 1, 8'd7, 32'hCAFE0007, "R6 write miss", h, st);
    check("R6/R8 memory updated on allocate", u_mem1.mem[7], 32'hCAFE0007);
    op(1, 0, 8'd7, 0, "R8 wt readback", h, st);
    check("R8 wt readback hits", 32'(h), 1);

    // R2 fill order
    do_flush(1);
    op(1, 0, 8'd2, 0, "R2", h, st); check("R2 first", 32'(h), 0);
    op(1, 0, 8'd4, 0, "R2", h, st); check("R2 second", 32'(h), 0);
    op(1, 0, 8'd2, 0, "R2", h, st); check("R2 way0 kept", 32'(h), 1);
    op(1, 0, 8'd4, 0, "R2", h, st); check("R2 way1 kept", 32'(h), 1);

    // R10 flush order
    do_flush(0);
    u_mem0.wlog_n = 0;
    op(0, 1, 8'd1, 32'hF1, "R10 set", h, st);
    op(0, 1, 8'd0, 32'hF0, "R10 set", h, st);
    op(0, 1, 8'd2, 32'hF2, "R10 set", h, st);
    do_flush(0);
    check("R10 write count", 32'(u_mem0.wlog_n), 3);
    check("R10 order 0", 32'(u_mem0.wlog[0]), 0);
    check("R10 order 1", 32'(u_mem0.wlog[1]), 2);
    check("R10 order 2", 32'(u_mem0.wlog[2]), 1);
    check("R10 data", u_mem0.mem[2], 32'hF2);
    op(0, 0, 8'd0, 0, "R10 invalidated", h, st);
    check("R10 miss after flush", 32'(h), 0);

    // random mix, R1 R3 R5
    for (int n = 0; n < 400; n++) begin
      int i = n % 2;
      op(i, 1'($urandom_range(0, 2) == 0), 8'($urandom_range(0, 15)), $urandom, "R3 random", h, st);
    end
    for (int a = 0; a < 16; a++) check("R6 wt memory current", u_mem1.mem[a], shadow[1][a]);
    do_flush(0);
    for (int a = 0; a < 16; a++) check("R7 memory after flush", u_mem0.mem[a], shadow[0][a]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule